// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This block watches every processor bus cycle and raises a break request when programmed conditions match. Two channels, A and B, each compare the cycle's address, data, cycle kind (instruction fetch or data access), direction and operand size against their own settings. Every address and data compare bit can be masked. Each channel picks its own address source and its own data source from two address buses and two data buses.

The channels either request breaks independently or form a sequence in which A must match in an earlier bus cycle than B. Channel B can also be told to break only on the Nth qualifying match. A fetch break can be taken before the fetched instruction executes, or held until the instruction retires. Software programs the block through a plain register write port and reads two sticky per-channel match flags. A flag is cleared by writing 1 to its bit.

Top module: `bus_break_cmp`

## Requirements
- R1: A channel matches only when `cyc_valid` is high and its control bit 0 (enable) is 1. A cycle with `cyc_valid` low never matches, never breaks and never sets a flag.
- R2: Address and data compares are 32 bits wide with a per-bit mask. A mask bit of 1 ignores that bit. A mask bit of 0 requires the selected bus bit to equal the value bit. Registers are addressed as {channel, field}: channel A at 0..4 and channel B at 8..12. The fields are address value (0), address mask (1), data value (2), data mask (3) and control (4).
- R3: Control bit 1 selects the address source (0: `addr_bus0`, 1: `addr_bus1`). Control bit 2 selects the data source (0: `data_bus0`, 1: `data_bus1`).
- R4: Control bits [4:3] qualify the kind: 00 any, 01 fetch only, 10 data only, 11 never. Bits [6:5] qualify the direction: 00 any, 01 read only, 10 write only, 11 never. Bits [8:7] qualify the size: 00 any, otherwise equal to `cyc_size` (01 byte, 10 word, 11 longword).
- R5: In independent mode (address 5, bit 0 = 0), a channel that fires and is not deferred drives `brk_req` high combinationally in the same cycle.
- R6: In sequential mode (address 5, bit 0 = 1), channel A never breaks on its own. Instead its match arms the sequence. Channel B counts a match only if the sequence was armed in an earlier cycle, so A and B matching in the same cycle do not complete it. The armed state clears when B's break fires and on any write to address 5.
- R7: Channel B breaks on the Nth qualifying match, where N is the 12-bit value at address 13. N of 0 or 1 breaks on every qualifying match. The match counter returns to zero when B's break fires and when address 13 is written.
- R8: When a firing channel has control bit 9 set and the cycle is a fetch, the break is deferred. `brk_req` is then raised in the first cycle with `insn_retire` high. A data cycle is never deferred.
- R9: `match_flags` bit 0 (A) and bit 1 (B) are set on the cycle after a qualifying match (for B, one that counts under R6) and stay set. Writing 1 to a bit of address 6 clears that flag. A new match in the same cycle wins over the clear.
- R10: After a synchronous reset, all settings are zero, `brk_req` is low, `match_flags` is 0, and the sequence, counter and deferred break are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address {channel, field} |
| cfg_wdata | input | 32 | Configuration write data |
| cyc_valid | input | 1 | Bus cycle present this clock |
| cyc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_size | input | 2 | Operand size: 01 byte, 10 word, 11 longword |
| addr_bus0 | input | 32 | First address bus |
| addr_bus1 | input | 32 | Second address bus |
| data_bus0 | input | 32 | First data bus |
| data_bus1 | input | 32 | Second data bus |
| insn_retire | input | 1 | Strobe marking a retired instruction |
| brk_req | output | 1 | Break request pulse |
| match_flags | output | 2 | Sticky match flags, bit 0 channel A, bit 1 channel B |

## Verification
Some rules are checked on every clock. A channel must stay silent in idle cycles. The arm must be taken after a lone channel A match in sequential mode. The repeat counter must stay below its limit and must return to zero after a rewrite. Flags must persist until cleared. A deferred break must drain on retirement, and `brk_req` must always have a cycle or retirement behind it. Other behaviour only shows in the bench's scenarios, which compare against an independent model. These cover the bus selection, the qualifier encodings, the same-cycle A-and-B case, re-arming after a mode write, and counting to the Nth match and counting again after a reprogram.

// File: rtl/bbc_pkg.sv
package bbc_pkg;

    localparam int BBC_ADDR_W = 32;
    localparam int BBC_DATA_W = 32;
    localparam int BBC_RPT_W  = 12;
    localparam int BBC_CHANS  = 2;
    localparam int BBC_CTRL_W = 10;

    // Per-channel control word, bit 0 at the bottom
    typedef struct packed {
        logic       defer_exec;   // bit 9
        logic [1:0] size_sel;     // bits 8:7
        logic [1:0] dir_sel;      // bits 6:5
        logic [1:0] kind_sel;     // bits 4:3
        logic       dbus_sel;     // bit 2
        logic       abus_sel;     // bit 1
        logic       enable;       // bit 0
    } ch_ctrl_t;

    typedef struct packed {
        logic       fetch;
        logic       write;
        logic [1:0] size;
    } cyc_attr_t;

    typedef enum logic [2:0] {
        FLD_AVAL  = 3'd0,
        FLD_AMSK  = 3'd1,
        FLD_DVAL  = 3'd2,
        FLD_DMSK  = 3'd3,
        FLD_CTRL  = 3'd4,
        FLD_EXTRA = 3'd5,
        FLD_CLEAR = 3'd6
    } cfg_field_e;

    // 00 any, 01 first-kind only, 10 second-kind only, 11 never
    function automatic logic qual_ok(input logic [1:0] sel, input logic is_first);
        return (sel == 2'b00) || (sel == 2'b01 && is_first) || (sel == 2'b10 && !is_first);
    endfunction

    function automatic logic size_ok(input logic [1:0] sel, input logic [1:0] sz);
        return (sel == 2'b00) || (sel == sz);
    endfunction

endpackage

// File: rtl/bbc_channel.sv
module bbc_channel
    import bbc_pkg::*;
#(
    parameter int ADDR_W = BBC_ADDR_W,
    parameter int DATA_W = BBC_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_valid,
    input  cyc_attr_t         attr,
    input  logic [ADDR_W-1:0] addr_bus0,
    input  logic [ADDR_W-1:0] addr_bus1,
    input  logic [DATA_W-1:0] data_bus0,
    input  logic [DATA_W-1:0] data_bus1,
    input  ch_ctrl_t          ctrl,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic [ADDR_W-1:0] addr_msk,
    input  logic [DATA_W-1:0] data_val,
    input  logic [DATA_W-1:0] data_msk,
    output logic              hit
);

    logic [ADDR_W-1:0] a_src;
    logic [DATA_W-1:0] d_src;
    logic              addr_ok, data_ok, attr_ok;

    always_comb begin
        a_src   = ctrl.abus_sel ? addr_bus1 : addr_bus0;
        d_src   = ctrl.dbus_sel ? data_bus1 : data_bus0;
        addr_ok = ((a_src ^ addr_val) & ~addr_msk) == '0;
        data_ok = ((d_src ^ data_val) & ~data_msk) == '0;
        attr_ok = qual_ok(ctrl.kind_sel, attr.fetch)
                & qual_ok(ctrl.dir_sel, !attr.write)
                & size_ok(ctrl.size_sel, attr.size);
        hit     = cyc_valid & ctrl.enable & addr_ok & data_ok & attr_ok;
    end

    // R1: idle bus cycles never produce a channel match
    a_r1_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |-> !hit);

endmodule

// File: rtl/bbc_seq.sv
module bbc_seq #(
    parameter int RPT_W = bbc_pkg::BBC_RPT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_a,
    input  logic             hit_b,
    input  logic             seq_mode,
    input  logic [RPT_W-1:0] rpt_lim,
    input  logic             clr_armed,
    input  logic             clr_cnt,
    output logic             fire_a,
    output logic             fire_b,
    output logic             evt_b
);

    logic             armed_q;
    logic [RPT_W-1:0] cnt_q;
    logic             reach;

    always_comb begin
        fire_a = hit_a & ~seq_mode;
        evt_b  = hit_b & (~seq_mode | armed_q);
        reach  = (rpt_lim <= RPT_W'(1))
               || (({1'b0, cnt_q} + 1'b1) == {1'b0, rpt_lim});
        fire_b = evt_b & reach;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (clr_armed) begin
            armed_q <= 1'b0;
        end else if (seq_mode && fire_b) begin
            armed_q <= 1'b0;
        end else if (seq_mode && hit_a) begin
            armed_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr_cnt || fire_b) begin
            cnt_q <= '0;
        end else if (evt_b) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: a lone A match in sequential mode leaves the sequence armed
    a_r6_arm_on_a: assert property (@(posedge clk) disable iff (rst)
        seq_mode && hit_a && !fire_b && !clr_armed |=> armed_q);

    // R7: the counter never reaches a limit above one
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (rpt_lim > RPT_W'(1)) |-> (cnt_q < rpt_lim));

    // R7: rewriting the limit restarts the count
    a_r7_cnt_restart: assert property (@(posedge clk) disable iff (rst)
        clr_cnt |=> (cnt_q == '0));

endmodule

// File: rtl/bus_break_cmp.sv
module bus_break_cmp
    import bbc_pkg::*;
#(
    parameter int ADDR_W = BBC_ADDR_W,
    parameter int DATA_W = BBC_DATA_W,
    parameter int RPT_W  = BBC_RPT_W,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              cyc_valid,
    input  logic              cyc_fetch,
    input  logic              cyc_write,
    input  logic [1:0]        cyc_size,
    input  logic [ADDR_W-1:0] addr_bus0,
    input  logic [ADDR_W-1:0] addr_bus1,
    input  logic [DATA_W-1:0] data_bus0,
    input  logic [DATA_W-1:0] data_bus1,
    input  logic              insn_retire,
    output logic              brk_req,
    output logic [1:0]        match_flags
);

    localparam int NCH = BBC_CHANS;

    logic [ADDR_W-1:0] aval_q [NCH];
    logic [ADDR_W-1:0] amsk_q [NCH];
    logic [DATA_W-1:0] dval_q [NCH];
    logic [DATA_W-1:0] dmsk_q [NCH];
    ch_ctrl_t          ctrl_q [NCH];
    logic              seq_q;
    logic [RPT_W-1:0]  lim_q;

    logic              wr_ch;
    logic [2:0]        wr_fld;
    logic              mode_wr, lim_wr;
    logic [1:0]        clr_vec;
    cyc_attr_t         attr;
    logic [NCH-1:0]    hit;
    logic              fire_a, fire_b, evt_b;
    logic              defer_a, defer_b, pend_set, now_req;
    logic              pend_q;
    logic [1:0]        flag_q;

    assign wr_ch   = cfg_addr[3];
    assign wr_fld  = cfg_addr[2:0];
    assign mode_wr = cfg_we && !wr_ch && wr_fld == FLD_EXTRA;
    assign lim_wr  = cfg_we &&  wr_ch && wr_fld == FLD_EXTRA;
    assign clr_vec = (cfg_we && !wr_ch && wr_fld == FLD_CLEAR) ? cfg_wdata[1:0] : 2'b00;
    assign attr    = {cyc_fetch, cyc_write, cyc_size};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                aval_q[c] <= '0;
                amsk_q[c] <= '0;
                dval_q[c] <= '0;
                dmsk_q[c] <= '0;
                ctrl_q[c] <= '0;
            end
            seq_q <= 1'b0;
            lim_q <= '0;
        end else if (cfg_we) begin
            case (wr_fld)
                FLD_AVAL:  aval_q[wr_ch] <= cfg_wdata[ADDR_W-1:0];
                FLD_AMSK:  amsk_q[wr_ch] <= cfg_wdata[ADDR_W-1:0];
                FLD_DVAL:  dval_q[wr_ch] <= cfg_wdata[DATA_W-1:0];
                FLD_DMSK:  dmsk_q[wr_ch] <= cfg_wdata[DATA_W-1:0];
                FLD_CTRL:  ctrl_q[wr_ch] <= ch_ctrl_t'(cfg_wdata[BBC_CTRL_W-1:0]);
                FLD_EXTRA: begin
                    if (wr_ch) lim_q <= cfg_wdata[RPT_W-1:0];
                    else       seq_q <= cfg_wdata[0];
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        bbc_channel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .cyc_valid (cyc_valid),
            .attr      (attr),
            .addr_bus0 (addr_bus0),
            .addr_bus1 (addr_bus1),
            .data_bus0 (data_bus0),
            .data_bus1 (data_bus1),
            .ctrl      (ctrl_q[g]),
            .addr_val  (aval_q[g]),
            .addr_msk  (amsk_q[g]),
            .data_val  (dval_q[g]),
            .data_msk  (dmsk_q[g]),
            .hit       (hit[g])
        );
    end

    bbc_seq #(.RPT_W(RPT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .hit_a     (hit[0]),
        .hit_b     (hit[1]),
        .seq_mode  (seq_q),
        .rpt_lim   (lim_q),
        .clr_armed (mode_wr),
        .clr_cnt   (lim_wr),
        .fire_a    (fire_a),
        .fire_b    (fire_b),
        .evt_b     (evt_b)
    );

    always_comb begin
        defer_a  = ctrl_q[0].defer_exec & cyc_fetch;
        defer_b  = ctrl_q[1].defer_exec & cyc_fetch;
        pend_set = (fire_a & defer_a) | (fire_b & defer_b);
        now_req  = (fire_a & ~defer_a) | (fire_b & ~defer_b);
        brk_req  = now_req | (pend_q & insn_retire);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            flag_q <= 2'b00;
        end else begin
            pend_q <= pend_set | (pend_q & ~insn_retire);
            flag_q <= (flag_q & ~clr_vec) | {evt_b, hit[0]};
        end
    end

    assign match_flags = flag_q;

    // R9: flags persist until a write-one clear
    a_r9_flag_a_sticky: assert property (@(posedge clk) disable iff (rst)
        flag_q[0] && !clr_vec[0] |=> flag_q[0]);
    a_r9_flag_b_sticky: assert property (@(posedge clk) disable iff (rst)
        flag_q[1] && !clr_vec[1] |=> flag_q[1]);

    // R8: a deferred break drains on retirement
    a_r8_pend_drain: assert property (@(posedge clk) disable iff (rst)
        pend_q && insn_retire && !pend_set |=> !pend_q);

    // R5: a request always has a bus cycle or a retirement behind it
    a_r5_req_cause: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> (cyc_valid || insn_retire));

endmodule

// File: tb/bus_break_cmp_tb_top.sv
module bus_break_cmp_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        cyc_valid, cyc_fetch, cyc_write;
    logic [1:0]  cyc_size;
    logic [31:0] abus0, abus1, dbus0, dbus1;
    logic        insn_retire;
    logic        brk_req;
    logic [1:0]  match_flags;

    int n_chk  = 0;
    int n_fail = 0;

    // bench shadow of the programmed settings and the expected state
    logic [31:0] s_av [2];
    logic [31:0] s_am [2];
    logic [31:0] s_dv [2];
    logic [31:0] s_dm [2];
    logic [9:0]  s_ctrl [2];
    logic        s_seq;
    logic [11:0] s_lim;
    logic        m_armed, m_pend;
    logic [11:0] m_cnt;
    logic [1:0]  m_flags;

    always #10 clk = ~clk;

    bus_break_cmp dut_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cyc_valid   (cyc_valid),
        .cyc_fetch   (cyc_fetch),
        .cyc_write   (cyc_write),
        .cyc_size    (cyc_size),
        .addr_bus0   (abus0),
        .addr_bus1   (abus1),
        .data_bus0   (dbus0),
        .data_bus1   (dbus1),
        .insn_retire (insn_retire),
        .brk_req     (brk_req),
        .match_flags (match_flags)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic m_hit(input int c);
        logic [31:0] a, d;
        logic [9:0]  k;
        k = s_ctrl[c];
        a = k[1] ? abus1 : abus0;
        d = k[2] ? dbus1 : dbus0;
        if (!cyc_valid || !k[0]) return 1'b0;
        if (((a ^ s_av[c]) & ~s_am[c]) != 0) return 1'b0;
        if (((d ^ s_dv[c]) & ~s_dm[c]) != 0) return 1'b0;
        if (k[4:3] == 2'b11 || (k[4:3] == 2'b01 && !cyc_fetch) || (k[4:3] == 2'b10 && cyc_fetch)) return 1'b0;
        if (k[6:5] == 2'b11 || (k[6:5] == 2'b01 && cyc_write) || (k[6:5] == 2'b10 && !cyc_write)) return 1'b0;
        if (k[8:7] != 2'b00 && k[8:7] != cyc_size) return 1'b0;
        return 1'b1;
    endfunction

    // Called at a falling edge with inputs applied; checks, then advances one clock.
    task automatic tick(input string tag, input int want);
        logic ha, hb, fa, ev, reach, fb, dfa, dfb, exp_req;
        logic [1:0] clr;
        #2;
        ha    = m_hit(0);
        hb    = m_hit(1);
        fa    = ha & !s_seq;
        ev    = hb & (!s_seq | m_armed);
        reach = (s_lim <= 1) || (int'(m_cnt) + 1 == int'(s_lim));
        fb    = ev & reach;
        dfa   = s_ctrl[0][9] & cyc_fetch;
        dfb   = s_ctrl[1][9] & cyc_fetch;
        exp_req = (fa & !dfa) | (fb & !dfb) | (m_pend & insn_retire);
        chk({tag, " brk_req model (R5 R6 R7 R8)"}, {31'd0, brk_req}, {31'd0, exp_req});
        chk({tag, " flags model (R9)"}, {30'd0, match_flags}, {30'd0, m_flags});
        if (want >= 0) chk({tag, " brk_req directed"}, {31'd0, brk_req}, want[31:0]);
        @(posedge clk);
        m_pend = (fa & dfa) | (fb & dfb) | (m_pend & !insn_retire);
        if (cfg_we && cfg_addr == 4'd5)  m_armed = 1'b0;
        else if (s_seq && fb)            m_armed = 1'b0;
        else if (s_seq && ha)            m_armed = 1'b1;
        if (cfg_we && cfg_addr == 4'd13) m_cnt = '0;
        else if (fb)                     m_cnt = '0;
        else if (ev)                     m_cnt = m_cnt + 1'b1;
        clr = (cfg_we && cfg_addr == 4'd6) ? cfg_wdata[1:0] : 2'b00;
        m_flags = (m_flags & ~clr) | {ev, ha};
        if (cfg_we) begin
            case (cfg_addr)
                4'd0:  s_av[0]   = cfg_wdata;
                4'd1:  s_am[0]   = cfg_wdata;
                4'd2:  s_dv[0]   = cfg_wdata;
                4'd3:  s_dm[0]   = cfg_wdata;
                4'd4:  s_ctrl[0] = cfg_wdata[9:0];
                4'd5:  s_seq     = cfg_wdata[0];
                4'd8:  s_av[1]   = cfg_wdata;
                4'd9:  s_am[1]   = cfg_wdata;
                4'd10: s_dv[1]   = cfg_wdata;
                4'd11: s_dm[1]   = cfg_wdata;
                4'd12: s_ctrl[1] = cfg_wdata[9:0];
                4'd13: s_lim     = cfg_wdata[11:0];
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        cyc_valid = 1'b0; insn_retire = 1'b0;
        tick("cfg", -1);
        cfg_we = 1'b0;
    endtask

    task automatic cyc(input logic v, input logic f, input logic w, input logic [1:0] sz,
                       input logic [31:0] a0, input logic [31:0] a1,
                       input logic [31:0] d0, input logic [31:0] d1,
                       input logic ret, input string tag, input int want);
        cyc_valid = v; cyc_fetch = f; cyc_write = w; cyc_size = sz;
        abus0 = a0; abus1 = a1; dbus0 = d0; dbus1 = d1; insn_retire = ret;
        tick(tag, want);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R10: run hung, actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        logic [31:0] pick;
        rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        cyc_valid = 0; cyc_fetch = 0; cyc_write = 0; cyc_size = 0;
        abus0 = 0; abus1 = 0; dbus0 = 0; dbus1 = 0; insn_retire = 0;
        for (int c = 0; c < 2; c++) begin
            s_av[c] = 0; s_am[c] = 0; s_dv[c] = 0; s_dm[c] = 0; s_ctrl[c] = 0;
        end
        s_seq = 0; s_lim = 0; m_armed = 0; m_pend = 0; m_cnt = 0; m_flags = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset brk_req", {31'd0, brk_req}, 32'd0);
        chk("R10 reset flags", {30'd0, match_flags}, 32'd0);
        rst = 1'b0;

        // R1 / R2 / R5: channel A address compare
        cfg_wr(4'd0, 32'h1000_0040);
        cfg_wr(4'd1, 32'h0);
        cfg_wr(4'd3, 32'hFFFF_FFFF);
        cfg_wr(4'd4, 32'h001);
        cyc(0, 0, 0, 2'b11, 32'h1000_0040, 0, 0, 0, 0, "R1 idle cycle", 0);
        chk("R1 idle sets no flag", {30'd0, match_flags}, 32'd0);
        cyc(1, 0, 0, 2'b11, 32'h1000_0040, 0, 0, 0, 0, "R5 independent A", 1);
        chk("R9 flag A set", {30'd0, match_flags}, 32'd1);
        cfg_wr(4'd1, 32'h0000_000F);
        cyc(1, 0, 0, 2'b11, 32'h1000_004F, 0, 0, 0, 0, "R2 masked bits", 1);
        cyc(1, 0, 0, 2'b11, 32'h1000_0050, 0, 0, 0, 0, "R2 unmasked bit", 0);

        // R3: bus selection
        cfg_wr(4'd4, 32'h003);
        cyc(1, 0, 0, 2'b11, 32'h1000_0040, 32'h0, 0, 0, 0, "R3 wrong addr bus", 0);
        cyc(1, 0, 0, 2'b11, 32'h0, 32'h1000_0040, 0, 0, 0, "R3 addr bus1", 1);
        cfg_wr(4'd2, 32'hCAFE_0001);
        cfg_wr(4'd3, 32'h0);
        cfg_wr(4'd4, 32'h007);
        cyc(1, 0, 0, 2'b11, 0, 32'h1000_0040, 32'hCAFE_0001, 32'h5, 0, "R3 wrong data bus", 0);
        cyc(1, 0, 0, 2'b11, 0, 32'h1000_0040, 32'h5, 32'hCAFE_0001, 0, "R3 data bus1", 1);

        // R4: data-only, write-only, word-only
        cfg_wr(4'd4, 32'h157);
        cyc(1, 0, 1, 2'b10, 0, 32'h1000_0040, 0, 32'hCAFE_0001, 0, "R4 data write word", 1);
        cyc(1, 0, 0, 2'b10, 0, 32'h1000_0040, 0, 32'hCAFE_0001, 0, "R4 read rejected", 0);
        cyc(1, 1, 1, 2'b10, 0, 32'h1000_0040, 0, 32'hCAFE_0001, 0, "R4 fetch rejected", 0);
        cyc(1, 0, 1, 2'b01, 0, 32'h1000_0040, 0, 32'hCAFE_0001, 0, "R4 byte rejected", 0);

        // R9: write-one clear
        chk("R9 flag A held", {30'd0, match_flags}, 32'd1);
        cfg_wr(4'd6, 32'h2);
        chk("R9 clear of other bit keeps A", {30'd0, match_flags}, 32'd1);
        cfg_wr(4'd6, 32'h1);
        chk("R9 flag A cleared", {30'd0, match_flags}, 32'd0);

        // R6: sequential A then B
        cfg_wr(4'd0, 32'h100); cfg_wr(4'd1, 0); cfg_wr(4'd3, 32'hFFFF_FFFF); cfg_wr(4'd4, 32'h001);
        cfg_wr(4'd8, 32'h200); cfg_wr(4'd9, 0); cfg_wr(4'd11, 32'hFFFF_FFFF); cfg_wr(4'd12, 32'h003);
        cfg_wr(4'd5, 32'h1);
        cyc(1, 0, 0, 2'b11, 0, 32'h200, 0, 0, 0, "R6 B before A", 0);
        chk("R6 unarmed B sets no flag", {30'd0, match_flags}, 32'd0);
        cyc(1, 0, 0, 2'b11, 32'h100, 0, 0, 0, 0, "R6 A alone no break", 0);
        cyc(1, 0, 0, 2'b11, 0, 32'h200, 0, 0, 0, "R6 B after A", 1);
        cyc(1, 0, 0, 2'b11, 32'h100, 32'h200, 0, 0, 0, "R6 same cycle", 0);
        cyc(1, 0, 0, 2'b11, 0, 32'h200, 0, 0, 0, "R6 B next cycle", 1);
        cyc(1, 0, 0, 2'b11, 32'h100, 0, 0, 0, 0, "R6 arm", 0);
        cfg_wr(4'd5, 32'h1);
        cyc(1, 0, 0, 2'b11, 0, 32'h200, 0, 0, 0, "R6 mode write disarms", 0);

        // R7: repeat count
        cfg_wr(4'd5, 32'h0);
        cfg_wr(4'd4, 32'h000);
        cfg_wr(4'd13, 32'd3);
        cyc(1, 0, 0, 2'b11, 0, 32'h200, 0, 0, 0, "R7 count 1", 0);
        cyc(1, 0, 0, 2'b11, 0, 32'h200, 0, 0, 0, "R7 count 2", 0);
        cyc(1, 0, 0, 2'b11, 0, 32'h200, 0, 0, 0, "R7 count 3", 1);
        cyc(1, 0, 0, 2'b11, 0, 32'h200, 0, 0, 0, "R7 restart 1", 0);
        cfg_wr(4'd13, 32'd3);
        cyc(1, 0, 0, 2'b11, 0, 32'h200, 0, 0, 0, "R7 after rewrite 1", 0);
        cyc(1, 0, 0, 2'b11, 0, 32'h200, 0, 0, 0, "R7 after rewrite 2", 0);
        cyc(1, 0, 0, 2'b11, 0, 32'h200, 0, 0, 0, "R7 after rewrite 3", 1);
        cfg_wr(4'd13, 32'd0);
        cfg_wr(4'd12, 32'h000);

        // R8: deferred fetch break
        cfg_wr(4'd4, 32'h209);
        cyc(1, 1, 0, 2'b11, 32'h100, 0, 0, 0, 0, "R8 deferred fetch", 0);
        cyc(0, 0, 0, 2'b00, 0, 0, 0, 0, 0, "R8 waiting", 0);
        cyc(0, 0, 0, 2'b00, 0, 0, 0, 0, 1, "R8 retire", 1);
        cyc(0, 0, 0, 2'b00, 0, 0, 0, 0, 1, "R8 drained", 0);
        cfg_wr(4'd4, 32'h201);
        cyc(1, 0, 0, 2'b11, 32'h100, 0, 0, 0, 0, "R8 data not deferred", 1);

        // constrained random phase, checked against the bench model
        seed = $urandom(32'h0BBC_5EED);
        for (int r = 0; r < 10; r++) begin
            for (int c = 0; c < 2; c++) begin
                cfg_wr(4'(c * 8 + 0), $urandom);
                cfg_wr(4'(c * 8 + 1), $urandom | $urandom | $urandom);
                cfg_wr(4'(c * 8 + 2), $urandom);
                cfg_wr(4'(c * 8 + 3), $urandom | 32'hFFFF_FF00);
                pick = $urandom & 32'h3FF;
                if ($urandom_range(0, 9) != 0) pick[0] = 1'b1;
                cfg_wr(4'(c * 8 + 4), pick);
            end
            cfg_wr(4'd5, 32'($urandom_range(0, 1)));
            cfg_wr(4'd13, 32'($urandom_range(0, 4)));
            for (int k = 0; k < 200; k++) begin
                if ($urandom_range(0, 19) == 0) begin
                    cfg_wr(4'd6, 32'($urandom_range(0, 3)));
                end else begin
                    cyc_valid   = ($urandom_range(0, 4) != 0);
                    cyc_fetch   = $urandom_range(0, 1) != 0;
                    cyc_write   = $urandom_range(0, 1) != 0;
                    cyc_size    = 2'($urandom_range(1, 3));
                    abus0       = ($urandom_range(0, 2) == 0) ? $urandom : s_av[$urandom_range(0, 1)];
                    abus1       = ($urandom_range(0, 2) == 0) ? $urandom : s_av[$urandom_range(0, 1)];
                    dbus0       = ($urandom_range(0, 2) == 0) ? $urandom : s_dv[$urandom_range(0, 1)];
                    dbus1       = ($urandom_range(0, 2) == 0) ? $urandom : s_dv[$urandom_range(0, 1)];
                    insn_retire = ($urandom_range(0, 2) == 0);
                    tick("random R1 R2 R3 R4", -1);
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule